// File: doc/BRIEF.md
# Two-Slot Receive Frame Buffer

This block sits behind the receive path of a small Ethernet-style MAC. Bytes arrive one per cycle on a stream that carries a valid strobe, an end-of-frame marker and an error flag. Each frame is packed into one of two on-chip buffers, called ping and pong. When a frame ends cleanly, the done flag of its buffer is raised. The buffer then stays closed to new traffic until software has read it and handed it back.

Software reads a buffer as aligned 32-bit words, counted from the start of the frame. Each buffer has a small status register that holds the done flag and an interrupt enable. Software releases a buffer by writing a zero into its done bit. A parameter removes the pong buffer entirely, and the block then runs with ping alone.

Top module: `rx_dualbuf`

## Requirements
- R1: After reset, both done flags and both interrupt enables read 0, `irq` is low, and the first frame is aimed at ping.
- R2: Byte n of a frame (counting from 0) is stored in word n/4, lane n%4, at bits [8*(n%4)+7 : 8*(n%4)]. Storing lane 0 of a word zeroes lanes 1 to 3 of that word.
- R3: Status bit 0 (done) of the target buffer reads 1 in the cycle after a clean final byte (last=1, err=0) is accepted.
- R4: With the pong buffer present, the target flips between ping and pong after each frame that completes cleanly, and only then.
- R5: A frame that starts while its target buffer has done=1 is discarded whole. That buffer's contents and status stay as they were, and the target does not move.
- R6: A frame whose final byte carries err=1 leaves done at 0 and does not move the target.
- R7: A status write stores bit 3 as the interrupt enable and ANDs bit 0 into done: writing 0 clears done, writing 1 never sets it. Writing 8 alone clears a pending frame and enables the interrupt.
- R8: `irq` is high for exactly the cycle in which done rises on a buffer whose interrupt enable is 1.
- R9: Bytes beyond BUF_WORDS*4 in a frame are discarded, and the frame still completes normally.
- R10: With DUAL=0, `st_pong` reads 0, status writes with `st_sel`=1 have no effect, and `rd_sel` is ignored: reads always come from ping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte strobe on the receive stream |
| in_data | input | 8 | Received byte |
| in_last | input | 1 | Marks the final byte of a frame |
| in_err | input | 1 | Error flag, evaluated on the final byte |
| st_we | input | 1 | Status register write strobe |
| st_sel | input | 1 | Status register select: 0 ping, 1 pong |
| st_wdata | input | 4 | Status write data: bit 0 done, bit 3 interrupt enable |
| rd_sel | input | 1 | Buffer to read: 0 ping, 1 pong |
| rd_word | input | $clog2(BUF_WORDS) | Word index within the buffer |
| rd_data | output | 32 | Word read, combinational |
| st_ping | output | 4 | Ping status {ie, 0, 0, done} |
| st_pong | output | 4 | Pong status {ie, 0, 0, done} |
| irq | output | 1 | One-cycle frame-received pulse |

## Verification
The bench builds two copies of the block from the same stimulus: one with DUAL=1 and one with DUAL=0. Both use BUF_WORDS=4, so a buffer holds 16 bytes. That small size makes the truncation case of R9 easy to reach with frames of up to 20 bytes. The twin build lets one frame sequence show alternation and full-drop in the two-buffer copy, and the ignored pong accesses in the single-buffer copy.

// File: rtl/rx_dualbuf.sv
module rx_dualbuf #(
  parameter bit DUAL      = 1'b1,
  parameter int BUF_WORDS = 16,
  localparam int AW       = $clog2(BUF_WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  input  logic          in_last,
  input  logic          in_err,
  input  logic          st_we,
  input  logic          st_sel,
  input  logic [3:0]    st_wdata,
  input  logic          rd_sel,
  input  logic [AW-1:0] rd_word,
  output logic [31:0]   rd_data,
  output logic [3:0]    st_ping,
  output logic [3:0]    st_pong,
  output logic          irq
);
  localparam int NB  = DUAL ? 2 : 1;
  localparam int CAP = BUF_WORDS * 4;
  localparam int CW  = $clog2(CAP + 1);
  localparam int MW  = $clog2(NB * BUF_WORDS);

  logic [31:0]   mem [NB*BUF_WORDS];
  logic [1:0]    done, ie;
  logic          tgt, busy, acc;
  logic [CW-1:0] cnt;

  logic          take, wr, fin;
  logic [CW-1:0] idx;
  logic [1:0]    lane;
  logic [MW-1:0] waddr, raddr;

  assign take  = busy ? acc : !done[tgt];
  assign idx   = busy ? cnt : '0;
  assign lane  = idx[1:0];
  assign wr    = in_valid && take && (idx < CW'(CAP));
  assign fin   = in_valid && in_last && take && !in_err;
  assign waddr = tgt ? MW'(BUF_WORDS) + MW'(idx[CW-1:2]) : MW'(idx[CW-1:2]);
  assign raddr = (DUAL && rd_sel) ? MW'(BUF_WORDS) + MW'(rd_word) : MW'(rd_word);
  assign rd_data = mem[raddr];

  always_ff @(posedge clk) begin
    if (wr) begin
      if (lane == 2'd0) mem[waddr] <= {24'b0, in_data};
      else              mem[waddr][{lane, 3'b000} +: 8] <= in_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      acc  <= 1'b0;
      cnt  <= '0;
    end else if (in_valid) begin
      if (in_last) begin
        busy <= 1'b0;
      end else begin
        busy <= 1'b1;
        acc  <= take;
        cnt  <= (idx == CW'(CAP)) ? idx : idx + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tgt  <= 1'b0;
      done <= '0;
      ie   <= '0;
      irq  <= 1'b0;
    end else begin
      if (fin && DUAL) tgt <= ~tgt;
      for (int b = 0; b < 2; b++) begin
        if (st_we && st_sel == 1'(b) && (DUAL || b == 0)) begin
          done[b] <= done[b] & st_wdata[0];
          ie[b]   <= st_wdata[3];
        end
        if (fin && tgt == 1'(b)) done[b] <= 1'b1;
      end
      irq <= fin && ie[tgt];
    end
  end

  assign st_ping = {ie[0], 2'b00, done[0]};
  assign st_pong = {ie[1], 2'b00, done[1]};
endmodule

module rx_dualbuf_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_last,
  input logic       in_err,
  input logic       st_we,
  input logic       st_sel,
  input logic [3:0] st_ping,
  input logic [3:0] st_pong,
  input logic       irq
);
  assert_irq_on_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($rose(st_ping[0]) || $rose(st_pong[0])));

  assert_ping_done_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_ping[0]) |-> $past(in_valid && in_last && !in_err));

  assert_pong_done_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_pong[0]) |-> $past(in_valid && in_last && !in_err));

  assert_ping_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_ping[0] && !(st_we && !st_sel)) |=> st_ping[0]);

  assert_pong_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_pong[0] && !(st_we && st_sel)) |=> st_pong[0]);

  assert_err_no_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_last && in_err) |=> !($rose(st_ping[0]) || $rose(st_pong[0])));
endmodule

bind rx_dualbuf rx_dualbuf_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_last(in_last),
  .in_err(in_err), .st_we(st_we), .st_sel(st_sel), .st_ping(st_ping),
  .st_pong(st_pong), .irq(irq)
);

// File: tb/tb_rx_dualbuf.sv
module tb_rx_dualbuf;
  localparam int PERIOD = 10;
  localparam int WORDS  = 4;
  localparam int CAP    = WORDS * 4;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_last = 0, in_err = 0;
  logic [7:0] in_data = 0;
  logic st_we = 0, st_sel = 0;
  logic [3:0] st_wdata = 0;
  logic rd_sel = 0;
  logic [1:0] rd_word = 0;
  logic [31:0] rd_d, rd_s;
  logic [3:0] sp_d, sq_d, sp_s, sq_s;
  logic irq_d, irq_s;

  always #(PERIOD/2) clk = ~clk;

  rx_dualbuf #(.DUAL(1'b1), .BUF_WORDS(WORDS)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_err(in_err), .st_we(st_we), .st_sel(st_sel),
    .st_wdata(st_wdata), .rd_sel(rd_sel), .rd_word(rd_word), .rd_data(rd_d),
    .st_ping(sp_d), .st_pong(sq_d), .irq(irq_d));

  rx_dualbuf #(.DUAL(1'b0), .BUF_WORDS(WORDS)) dut_single (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_err(in_err), .st_we(st_we), .st_sel(st_sel),
    .st_wdata(st_wdata), .rd_sel(rd_sel), .rd_word(rd_word), .rd_data(rd_s),
    .st_ping(sp_s), .st_pong(sq_s), .irq(irq_s));

  int n_chk = 0, n_fail = 0;
  bit [31:0] mm [2][2][WORDS];
  bit        mv [2][2][WORDS];
  bit        md [2][2];
  bit        mi [2][2];
  bit        mt [2];
  int        irq_exp [2];
  int        irq_cnt [2];
  bit [7:0]  fb [32];

  always @(posedge clk) begin
    if (rst_n && irq_d) irq_cnt[0]++;
    if (rst_n && irq_s) irq_cnt[1]++;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit [3:0] stat(int i, int b);
    if (i == 1 && b == 1) return 4'h0;
    return {mi[i][b], 2'b00, md[i][b]};
  endfunction

  task automatic verify(string req);
    @(negedge clk);
    chk({req, " ping status dual"}, 32'(sp_d), 32'(stat(0, 0)));
    chk({req, " pong status dual"}, 32'(sq_d), 32'(stat(0, 1)));
    chk({req, " ping status single"}, 32'(sp_s), 32'(stat(1, 0)));
    chk({req, " R10 pong status single"}, 32'(sq_s), 32'(stat(1, 1)));
    chk({req, " R8 irq count dual"}, irq_cnt[0], irq_exp[0]);
    chk({req, " R8 irq count single"}, irq_cnt[1], irq_exp[1]);
    for (int b = 0; b < 2; b++)
      for (int w = 0; w < WORDS; w++) begin
        @(negedge clk);
        rd_sel = 1'(b); rd_word = 2'(w);
        #1;
        if (mv[0][b][w]) chk({req, " R2 word dual"}, rd_d, mm[0][b][w]);
        if (mv[1][0][w]) chk({req, " R10 word single"}, rd_s, mm[1][0][w]);
      end
  endtask

  task automatic st_write(bit sel, bit [3:0] wd);
    @(negedge clk);
    st_we = 1; st_sel = sel; st_wdata = wd;
    @(negedge clk);
    st_we = 0;
    for (int i = 0; i < 2; i++) begin
      if (i == 1 && sel) continue;
      md[i][sel] = md[i][sel] & wd[0];
      mi[i][sel] = wd[3];
    end
  endtask

  task automatic send(int len, bit err, bit gaps);
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      if (gaps && ($urandom % 3 == 0)) begin
        in_valid = 0;
        @(negedge clk);
      end
      in_valid = 1; in_data = fb[k];
      in_last = (k == len - 1); in_err = (k == len - 1) ? err : 1'b0;
    end
    @(negedge clk);
    in_valid = 0; in_last = 0; in_err = 0;
    for (int i = 0; i < 2; i++) begin
      bit acc = !md[i][mt[i]];
      for (int k = 0; k < len; k++)
        if (acc && k < CAP) begin
          if (k % 4 == 0) mm[i][mt[i]][k/4] = {24'b0, fb[k]};
          else mm[i][mt[i]][k/4][8*(k%4) +: 8] = fb[k];
          mv[i][mt[i]][k/4] = 1;
        end
      if (acc && !err) begin
        md[i][mt[i]] = 1;
        if (mi[i][mt[i]]) irq_exp[i]++;
        if (i == 0) mt[i] = ~mt[i];
      end
    end
  endtask

  task automatic fill(int len);
    for (int k = 0; k < len; k++) fb[k] = 8'($urandom);
  endtask

  initial begin
    #(PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd7311));
    repeat (3) @(negedge clk);
    rst_n = 1;
    verify("R1 reset");
    chk("R1 irq low", 32'(irq_d | irq_s), 0);

    fill(6);  send(6, 0, 0);  verify("R3 first frame to ping");
    fill(3);  send(3, 0, 1);  verify("R4 second frame to pong");
    fill(5);  send(5, 0, 0);  verify("R5 both full drop");
    st_write(0, 4'b1000);     verify("R7 init clears done sets ie");
    st_write(0, 4'b1001);     verify("R7 write one does not set done");
    fill(4);  send(4, 1, 0);  verify("R6 error frame");
    fill(20); send(20, 0, 1); verify("R9 truncated frame with R8 irq");
    st_write(1, 4'b0000);     verify("R10 pong write");

    for (int it = 0; it < 200; it++) begin
      if ($urandom % 5 < 3) begin
        int len = 1 + $urandom % 20;
        fill(len);
        send(len, ($urandom % 6) == 0, $urandom % 2);
        verify("R4 R5 R6 random frame");
      end else begin
        st_write($urandom % 2, {$urandom % 2 == 0, 2'b00, $urandom % 4 == 0});
        verify("R7 random status write");
      end
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule